// File: doc/BRIEF.md
# Four-Tap Shift-Add Filter Engine

This block captures a burst of signed 8-bit samples into an on-block register-file memory and then runs a fixed four-tap filter over the stored burst. Each result goes into a second memory of the same size. The filter weights are -1/2, -2, +4 and +1/4. They apply to the current sample and to the three samples before it, and any sample before the start of the burst counts as zero. Every weight is a power of two, so each product is a shifted copy of a sample. The products are summed over four cycles on a single shared adder. Subtraction uses the inverted operand with a carry-in of one. The sum is floored to an integer and then clamped to the 8-bit signed range.

A rising edge on `start` opens a run. From the following clock on, one sample per cycle is taken from `data_in`, filling addresses 0 to 1023 in order. Computation then begins. Each output takes four accumulate cycles and one store cycle. When the last output has been stored, `done` goes high. It stays high until the next rising edge of `start`, which begins a new run. Between runs, a test read port returns words from the result memory combinationally.

Top module: `fir4_engine`

## Requirements
- R1: While reset is asserted and after it is released, `done` is 0. No run starts until `start` has been seen low and then high.
- R2: When `start` is sampled at 1 on a clock edge and was 0 on the previous edge, the sample on `data_in` at each of the next 1024 rising edges is stored at addresses 0, 1, ..., 1023 in that order.
- R3: Result word n (n = 0..1023) equals -X(n)/2 - 2X(n-1) + 4X(n-2) + X(n-3)/4, where X(k) = 0 for k < 0 and X is the stored sample.
- R4: A fractional part of the exact result is dropped by rounding toward minus infinity. For example, -0.5 gives -1 and +0.5 gives 0.
- R5: A result above +127 is stored as 0x7F, and a result below -128 is stored as 0x80.
- R6: `done` rises exactly 6144 clock edges after the edge that sampled the start edge (1024 load cycles plus 5 cycles per output). It then stays high until the next accepted start edge, and it falls on that edge.
- R7: A rising edge of `start` during a run is ignored. Holding `start` high after `done` does not begin a new run.
- R8: When `tp_rd_en` is 1 and no run is in progress, `tp_data` is the result word at `tp_addr`, combinationally. When `tp_rd_en` is 0, `tp_data` is 0.
- R9: A later run overwrites both memories, so the results read afterwards reflect only the newest burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Run request; a 0-to-1 transition is acted on when idle |
| data_in | input | 8 | Signed sample stream during loading |
| done | output | 1 | High once all results are stored, until the next run |
| tp_rd_en | input | 1 | Test read enable for the result memory |
| tp_addr | input | 10 | Test read address |
| tp_data | output | 8 | Test read data, 0 when not enabled |

## Verification
Some properties are checked by assertions on every cycle. The accumulator stays within the bound that the four weighted terms can reach. The first term of each output enters with its sign applied. Loading advances one address per clock and wraps into computation. A start edge seen during computation never leaves the run. `done` holds until a fresh start edge. Other behaviours can only be shown by the bench scenarios: the filter values, the floor rounding, both saturation limits, the exact cycle on which `done` rises, the zero-filled history at the start of a burst, and results being replaced on a rerun. The bench shows these by reading back every result word after several sample patterns and by comparing `done` with a timing model on every clock.

// File: rtl/fir4_pkg.sv
package fir4_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CALC,
    ST_STORE,
    ST_DONE
  } fir_state_e;

  // accumulator keeps two fractional bits: all terms are scaled by 4
  localparam int FRAC_BITS = 2;
  localparam int NUM_TAPS  = 4;

  // left shift applied to the sample (already scaled by 4) for each tap
  function automatic int tap_shift(input logic [1:0] t);
    case (t)
      2'd0:    return 1;  // 1/2 * 4
      2'd1:    return 3;  // 2   * 4
      2'd2:    return 4;  // 4   * 4
      default: return 0;  // 1/4 * 4
    endcase
  endfunction

  // taps 0 and 1 carry a negative weight
  function automatic logic tap_negative(input logic [1:0] t);
    return (t == 2'd0) || (t == 2'd1);
  endfunction

endpackage

// File: rtl/fir4_regfile.sv
module fir4_regfile #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              cs,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (cs && wr) begin
      store_q[addr] <= wdata;
    end
  end

  assign rdata = (cs && rd) ? store_q[addr] : '0;

endmodule

// File: rtl/fir4_datapath.sv
module fir4_datapath
  import fir4_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ACC_W = DATA_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              first,
  input  logic [1:0]        tap,
  input  logic              x_valid,
  input  logic [DATA_W-1:0] x_in,
  output logic [DATA_W-1:0] y_out
);

  localparam logic signed [ACC_W-1:0] Y_MAX = ACC_W'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] Y_MIN = -ACC_W'(2 ** (DATA_W - 1));
  localparam logic signed [ACC_W-1:0] BOUND = ACC_W'(27 * (2 ** (DATA_W - 1)));

  logic signed [ACC_W-1:0] x_ext;
  logic signed [ACC_W-1:0] term;
  logic signed [ACC_W-1:0] opnd_a;
  logic signed [ACC_W-1:0] opnd_b;
  logic signed [ACC_W-1:0] sum;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] y_floor;
  logic                    neg;

  always_comb begin
    x_ext  = x_valid ? ACC_W'($signed(x_in)) : '0;
    term   = x_ext <<< tap_shift(tap);
    neg    = tap_negative(tap);
    opnd_a = first ? '0 : acc_q;
    opnd_b = neg ? ~term : term;
    // the single adder of the block
    sum    = opnd_a + opnd_b + ACC_W'(neg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= sum;
    end
  end

  always_comb begin
    y_floor = acc_q >>> FRAC_BITS;
    if (y_floor > Y_MAX) begin
      y_out = Y_MAX[DATA_W-1:0];
    end else if (y_floor < Y_MIN) begin
      y_out = Y_MIN[DATA_W-1:0];
    end else begin
      y_out = y_floor[DATA_W-1:0];
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q <= BOUND) && (acc_q >= -BOUND));

  assert_first_term_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && first && neg) |=> (acc_q == -$past(term)));

endmodule

// File: rtl/fir4_ctrl.sv
module fir4_ctrl
  import fir4_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              load_wr,
  output logic              calc_rd,
  output logic [ADDR_W-1:0] src_addr,
  output logic              acc_en,
  output logic              first,
  output logic [1:0]        tap,
  output logic              x_valid,
  output logic              store_wr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              busy,
  output logic              done
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);
  localparam logic [1:0]        LAST_TAP = 2'(NUM_TAPS - 1);

  fir_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [1:0]        tap_q, tap_d;
  logic              start_q;
  logic              start_rise;
  logic [ADDR_W-1:0] tap_ext;

  assign start_rise = start && !start_q;
  assign tap_ext    = ADDR_W'(tap_q);

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    tap_d   = tap_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_rise) begin
          state_d = ST_LOAD;
          addr_d  = '0;
        end
      end
      ST_LOAD: begin
        if (addr_q == LAST) begin
          state_d = ST_CALC;
          addr_d  = '0;
          tap_d   = '0;
        end else begin
          addr_d = addr_q + ADDR_W'(1);
        end
      end
      ST_CALC: begin
        if (tap_q == LAST_TAP) begin
          state_d = ST_STORE;
        end else begin
          tap_d = tap_q + 2'd1;
        end
      end
      ST_STORE: begin
        tap_d = '0;
        if (addr_q == LAST) begin
          state_d = ST_DONE;
        end else begin
          state_d = ST_CALC;
          addr_d  = addr_q + ADDR_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      tap_q   <= '0;
      start_q <= 1'b1;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      tap_q   <= tap_d;
      start_q <= start;
    end
  end

  always_comb begin
    load_wr  = (state_q == ST_LOAD);
    calc_rd  = (state_q == ST_CALC);
    acc_en   = (state_q == ST_CALC);
    store_wr = (state_q == ST_STORE);
    first    = (tap_q == 2'd0);
    tap      = tap_q;
    x_valid  = (addr_q >= tap_ext);
    src_addr = (state_q == ST_CALC) ? (addr_q - tap_ext) : addr_q;
    dst_addr = addr_q;
    busy     = (state_q == ST_LOAD) || (state_q == ST_CALC) || (state_q == ST_STORE);
    done     = (state_q == ST_DONE);
  end

  assert_load_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD && addr_q != LAST) |=>
      (state_q == ST_LOAD && addr_q == $past(addr_q) + ADDR_W'(1)));

  assert_load_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD && addr_q == LAST) |=> (state_q == ST_CALC && addr_q == '0));

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CALC && start_rise) |=> (state_q == ST_CALC || state_q == ST_STORE));

  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start_rise) |=> done);

endmodule

// File: rtl/fir4_engine.sv
module fir4_engine #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] data_in,
  output logic              done,
  input  logic              tp_rd_en,
  input  logic [ADDR_W-1:0] tp_addr,
  output logic [DATA_W-1:0] tp_data
);

  logic              load_wr;
  logic              calc_rd;
  logic [ADDR_W-1:0] src_addr;
  logic              acc_en;
  logic              first;
  logic [1:0]        tap;
  logic              x_valid;
  logic              store_wr;
  logic [ADDR_W-1:0] dst_addr;
  logic              busy;
  logic [DATA_W-1:0] x_word;
  logic [DATA_W-1:0] y_word;
  logic              b_rd;
  logic [ADDR_W-1:0] b_addr;

  fir4_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .load_wr  (load_wr),
    .calc_rd  (calc_rd),
    .src_addr (src_addr),
    .acc_en   (acc_en),
    .first    (first),
    .tap      (tap),
    .x_valid  (x_valid),
    .store_wr (store_wr),
    .dst_addr (dst_addr),
    .busy     (busy),
    .done     (done)
  );

  fir4_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_src_mem (
    .clk   (clk),
    .cs    (load_wr || calc_rd),
    .wr    (load_wr),
    .rd    (calc_rd),
    .addr  (src_addr),
    .wdata (data_in),
    .rdata (x_word)
  );

  fir4_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_en  (acc_en),
    .first   (first),
    .tap     (tap),
    .x_valid (x_valid),
    .x_in    (x_word),
    .y_out   (y_word)
  );

  assign b_rd   = tp_rd_en && !busy;
  assign b_addr = busy ? dst_addr : tp_addr;

  fir4_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dst_mem (
    .clk   (clk),
    .cs    (store_wr || b_rd),
    .wr    (store_wr),
    .rd    (b_rd),
    .addr  (b_addr),
    .wdata (y_word),
    .rdata (tp_data)
  );

endmodule

// File: tb/sim_fir4_engine.sv
module sim_fir4_engine;

  localparam int N       = 1024;
  localparam int RUN_CYC = 6144;
  localparam int WD_CYC  = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] data_in = '0;
  logic       done;
  logic       tp_rd_en = 1'b0;
  logic [9:0] tp_addr = '0;
  logic [7:0] tp_data;

  int vectors = 0;
  int miscompares = 0;
  int xs [N];

  // behavioural timing model
  bit m_busy = 1'b0;
  bit m_done = 1'b0;
  bit m_prev = 1'b1;
  int m_cnt  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fir4_engine u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .data_in  (data_in),
    .done     (done),
    .tp_rd_en (tp_rd_en),
    .tp_addr  (tp_addr),
    .tp_data  (tp_data)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_prev = 1'b1; m_cnt = 0;
    end else begin
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == RUN_CYC) begin m_busy = 1'b0; m_done = 1'b1; end
      end else if (start && !m_prev) begin
        m_busy = 1'b1; m_cnt = 0; m_done = 1'b0;
      end
      m_prev = start;
    end
  end

  // R1 / R6 / R7: done compared with the model on every clock
  always @(negedge clk) begin
    if (!finished) begin
      vectors++;
      if (done !== m_done) begin
        miscompares++;
        $display("FAIL %s done: actual %0b expected %0b at %0t",
                 rst_n ? "R6/R7" : "R1", done, m_done, $time);
      end
    end
  end

  function automatic int gen(int p, int i);
    case (p)
      0: return ((i * 37 + 11) % 256) - 128;
      1: return (i % 2 == 1) ? 127 : -128;
      2: return (((i >> 1) & 1) == 1) ? -128 : 127;
      default: return (i % 7) - 3;
    endcase
  endfunction

  function automatic int xv(int k);
    return (k < 0) ? 0 : xs[k];
  endfunction

  function automatic int exact4(int n);
    return -2 * xv(n) - 8 * xv(n - 1) + 16 * xv(n - 2) + xv(n - 3);
  endfunction

  function automatic int ref_y(int n);
    int f;
    f = exact4(n) >>> 2;
    if (f > 127) f = 127;
    if (f < -128) f = -128;
    return f;
  endfunction

  task automatic report_summary();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic run(int p, bit poke_start);
    for (int i = 0; i < N; i++) xs[i] = gen(p, i);
    @(negedge clk) start = 1'b0;
    @(negedge clk) start = 1'b1;
    for (int i = 0; i < N; i++) begin
      @(negedge clk) data_in = xs[i][7:0];
    end
    if (poke_start) begin
      // R7: extra start edge during computation must be ignored
      repeat (100) @(negedge clk);
      start = 1'b0;
      @(negedge clk) start = 1'b1;
    end
    while (!m_done) @(negedge clk);
    // R7: start held high, no new run for a while
    repeat (40) @(negedge clk);
  endtask

  task automatic readback(int p);
    string tag;
    int e;
    int ex;
    for (int n = 0; n < N; n++) begin
      @(negedge clk);
      tp_rd_en = 1'b1;
      tp_addr  = n[9:0];
      #1;
      e  = ref_y(n);
      ex = exact4(n);
      if (n < 3) tag = "R3";
      else if (ex > 4 * 127 + 3 || ex < -4 * 128) tag = "R5";
      else if ((ex & 3) != 0) tag = "R4";
      else tag = "R3";
      vectors++;
      if ($signed(tp_data) !== e) begin
        miscompares++;
        $display("FAIL %s/R2/R9 pattern %0d y[%0d]: actual %0d expected %0d",
                 tag, p, n, $signed(tp_data), e);
      end
    end
    // R8: disabled read gives zero
    @(negedge clk);
    tp_rd_en = 1'b0;
    tp_addr  = 10'd5;
    #1;
    vectors++;
    if (tp_data !== 8'd0) begin
      miscompares++;
      $display("FAIL R8 disabled read: actual %0d expected 0", tp_data);
    end
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    report_summary();
  end

  initial begin
    // R1: start held high through reset must not launch a run
    start = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    run(0, 1'b0);
    readback(0);
    run(1, 1'b1);
    readback(1);
    run(2, 1'b0);
    readback(2);
    run(3, 1'b1);
    readback(3);
    repeat (5) @(negedge clk);
    report_summary();
  end

endmodule